// File: doc/BRIEF.md
# Bitstream Header Clock-Ratio Selector

This block sits beside a 32-bit configuration data path and watches the words of a configuration image as they stream past. It counts the accepted words of the current stream and captures two header indicators at fixed word positions: an encryption field and an active-low compression flag. It combines them with the selected bus width (16 or 32 bits) and produces the code for the ratio between the configuration clock and the data words, together with the width bit that the data path should use.

Once the compression word has been seen, a valid flag rises and the result stays frozen until the next stream begins. If a stream ends before the minimum header length has arrived, an error flag rises instead. A separate padding mode forces the ratio to the lowest setting while all-ones sync words are sent. The mode ends when the target reports early user mode, and the stored ratio then shows again. The block only decides the ratio. Generating the configuration clock is left to the logic that reads the code.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset, `ratio_code`, `width_32`, `hdr_valid` and `hdr_error` are all 0.
- R2: Word index 69 of a stream (counting accepted words from 0 after `s_start`) marks the image as encrypted when its bits [3:2] are nonzero (01, 10 and 11 all count as encrypted).
- R3: Word index 229 marks the image as compressed when its bit 1 is 0 and as uncompressed when it is 1. The bits of that word at [3:2] are not used.
- R4: An image that is neither encrypted nor compressed gets ratio code 0 (x1) at either width.
- R5: A compressed image gets code 2 (x4) at 16-bit width and code 3 (x8) at 32-bit width, whether encrypted or not.
- R6: An encrypted, uncompressed image gets code 1 (x2) at 16-bit width and code 2 (x4) at 32-bit width.
- R7: `hdr_valid` is 0 while word 229 is presented and rises in the cycle after it is accepted. `width_32` then equals `wide_sel` as sampled with word 229 (1 = 32-bit), and later changes of `wide_sel` have no effect.
- R8: `s_end` raises `hdr_error` in the next cycle when fewer than 230 words have been accepted, counting a word accepted in the same cycle as `s_end`. A stream of 230 or more words raises no error.
- R9: The result (code, width, valid, error) holds until the next `s_start`, which clears all four to 0 in the following cycle.
- R10: A `pad_start` pulse forces `ratio_code` to 0 from the next cycle on. The mode ends in the cycle after `early_user` is high, and the stored code then shows again. `early_user` wins when both are high. The width bit is not affected.
- R11: Data on cycles with `s_valid` low, at word positions other than 69 and 229, and words presented after `s_end` (until the next `s_start`) do not affect any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_start | input | 1 | Pulse that opens a new stream and clears the result; no word is taken in that cycle |
| s_data | input | 32 | Configuration word |
| s_valid | input | 1 | Word strobe; `s_data` is accepted when high |
| s_end | input | 1 | Pulse marking the end of the stream; may coincide with the last word |
| wide_sel | input | 1 | Bus width select, 1 = 32-bit, 0 = 16-bit |
| pad_start | input | 1 | Pulse entering sync-padding mode |
| early_user | input | 1 | Target reports early user mode; ends padding mode |
| ratio_code | output | 2 | Ratio code: 0 = x1, 1 = x2, 2 = x4, 3 = x8 |
| width_32 | output | 1 | Width setting captured with the header |
| hdr_valid | output | 1 | Both header indicators have been captured |
| hdr_error | output | 1 | Stream ended before the minimum header length |

## Verification
The hardest case to reach is a short stream that keeps running after its end marker: words pushed after `s_end` would reach index 229 if the counter were not frozen, and could set a valid result together with the error. The stimulus ends a stream at exactly 229 words and then presents one more word that marks the image as compressed. It also ends a 230-word stream with `s_end` on the final word, which checks the boundary where the same-cycle word must count. Padding mode is entered over a stored x8 result, so the forced x1 and the restored x8 are both visible at the port.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

    localparam int WORD_W    = 32;
    localparam int MIN_WORDS = 230;
    localparam int ENC_IDX   = 69;
    localparam int CMP_IDX   = 229;
    localparam int ENC_LSB   = 2;
    localparam int CMP_BIT   = 1;

    // Consecutive codes: doubling the ratio is one step up.
    typedef enum logic [1:0] {
        RATIO_X1 = 2'd0,
        RATIO_X2 = 2'd1,
        RATIO_X4 = 2'd2,
        RATIO_X8 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic   valid;
        logic   error;
        logic   wide;
        ratio_e ratio;
    } hdr_result_t;

    function automatic ratio_e pick_ratio(input logic enc, input logic cmp, input logic wide);
        ratio_e r;
        if (!enc && !cmp) begin
            r = RATIO_X1;
        end else begin
            r = cmp ? RATIO_X4 : RATIO_X2;
            if (wide) r = ratio_e'(r + 2'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
    parameter int MIN_WORDS = 230,
    parameter int ENC_IDX   = 69,
    parameter int CMP_IDX   = 229,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             word_in,
    input  logic             end_in,
    output logic [CNT_W-1:0] count,
    output logic             hit_enc,
    output logic             hit_cmp,
    output logic             short_end
);

    logic             done;
    logic             take;
    logic [CNT_W:0]   seen;

    assign take    = word_in && !done;
    assign hit_enc = take && (count == CNT_W'(ENC_IDX));
    assign hit_cmp = take && (count == CNT_W'(CMP_IDX));
    assign seen    = {1'b0, count} + (CNT_W+1)'(take);
    assign short_end = end_in && !done && (seen < (CNT_W+1)'(MIN_WORDS));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            done  <= 1'b0;
        end else begin
            if (take && (count != CNT_W'(MIN_WORDS))) count <= count + 1'b1;
            if (end_in) done <= 1'b1;
        end
    end

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture
    import hdr_ratio_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ENC_POS = 2,
    parameter int CMP_POS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              hit_enc,
    input  logic              hit_cmp,
    input  logic              short_end,
    input  logic [DATA_W-1:0] data,
    input  logic              wide_sel,
    output hdr_result_t       res
);

    logic enc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            enc_q <= 1'b0;
            res   <= '0;
        end else begin
            if (hit_enc) enc_q <= |data[ENC_POS +: 2];
            if (hit_cmp) begin
                res.valid <= 1'b1;
                res.wide  <= wide_sel;
                res.ratio <= pick_ratio(enc_q, !data[CMP_POS], wide_sel);
            end
            if (short_end) res.error <= 1'b1;
        end
    end

endmodule

// File: rtl/hdr_pad_ctrl.sv
module hdr_pad_ctrl
    import hdr_ratio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pad_start,
    input  logic   early_user,
    input  ratio_e stored,
    output ratio_e ratio_out,
    output logic   pad_active
);

    always_ff @(posedge clk) begin
        if (rst)             pad_active <= 1'b0;
        else if (early_user) pad_active <= 1'b0;
        else if (pad_start)  pad_active <= 1'b1;
    end

    assign ratio_out = pad_active ? RATIO_X1 : stored;

endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
    import hdr_ratio_pkg::*;
#(
    parameter int DATA_W    = WORD_W,
    parameter int MIN_LEN   = MIN_WORDS,
    parameter int ENC_WORD  = ENC_IDX,
    parameter int CMP_WORD  = CMP_IDX,
    parameter int ENC_FIELD = ENC_LSB,
    parameter int CMP_FLAG  = CMP_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_start,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_end,
    input  logic              wide_sel,
    input  logic              pad_start,
    input  logic              early_user,
    output logic [1:0]        ratio_code,
    output logic              width_32,
    output logic              hdr_valid,
    output logic              hdr_error
);

    localparam int CNT_W = $clog2(MIN_LEN + 1);

    logic [CNT_W-1:0] word_cnt;
    logic             hit_enc;
    logic             hit_cmp;
    logic             short_end;
    logic             pad_active;
    hdr_result_t      res;
    ratio_e           ratio_out;

    hdr_word_counter #(
        .MIN_WORDS (MIN_LEN),
        .ENC_IDX   (ENC_WORD),
        .CMP_IDX   (CMP_WORD),
        .CNT_W     (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .clear     (s_start),
        .word_in   (s_valid && !s_start),
        .end_in    (s_end && !s_start),
        .count     (word_cnt),
        .hit_enc   (hit_enc),
        .hit_cmp   (hit_cmp),
        .short_end (short_end)
    );

    hdr_flag_capture #(
        .DATA_W  (DATA_W),
        .ENC_POS (ENC_FIELD),
        .CMP_POS (CMP_FLAG)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .clear     (s_start),
        .hit_enc   (hit_enc),
        .hit_cmp   (hit_cmp),
        .short_end (short_end),
        .data      (s_data),
        .wide_sel  (wide_sel),
        .res       (res)
    );

    hdr_pad_ctrl u_pad (
        .clk        (clk),
        .rst        (rst),
        .pad_start  (pad_start),
        .early_user (early_user),
        .stored     (res.ratio),
        .ratio_out  (ratio_out),
        .pad_active (pad_active)
    );

    assign ratio_code = ratio_out;
    assign width_32   = res.wide;
    assign hdr_valid  = res.valid;
    assign hdr_error  = res.error;

endmodule

// File: rtl/hdr_ratio_sel_chk.sv
module hdr_ratio_sel_chk #(
    parameter int CNT_W    = 8,
    parameter int CMP_WORD = 229
) (
    input logic             clk,
    input logic             rst,
    input logic             s_start,
    input logic             s_valid,
    input logic             pad_start,
    input logic             early_user,
    input logic [CNT_W-1:0] word_cnt,
    input logic [1:0]       ratio_code,
    input logic             width_32,
    input logic             hdr_valid,
    input logic             hdr_error
);

    // R7: the word at the compression position makes the result valid next cycle
    a_r7_valid_follows_cmp: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_start && !hdr_valid && !hdr_error && word_cnt == CNT_W'(CMP_WORD)) |=> hdr_valid);

    // R9: stream start clears the result
    a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
        s_start |=> (!hdr_valid && !hdr_error));

    // R9: a valid result stays valid with the same width until a start
    a_r9_result_holds: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !s_start) |=> (hdr_valid && $stable(width_32)));

    // R10: padding mode forces the x1 code
    a_r10_pad_forces_x1: assert property (@(posedge clk) disable iff (rst)
        (pad_start && !early_user) |=> (ratio_code == 2'd0));

    // R4/R6: at 16-bit width the code never reaches x8
    a_r6_narrow_below_x8: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && !width_32) |-> (ratio_code != 2'd3));

    // R8/R11: an early end never coexists with a valid result
    a_r8_error_excludes_valid: assert property (@(posedge clk) disable iff (rst)
        hdr_error |-> !hdr_valid);

endmodule

bind hdr_ratio_sel hdr_ratio_sel_chk #(
    .CNT_W    (CNT_W),
    .CMP_WORD (CMP_WORD)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .s_start    (s_start),
    .s_valid    (s_valid),
    .pad_start  (pad_start),
    .early_user (early_user),
    .word_cnt   (word_cnt),
    .ratio_code (ratio_code),
    .width_32   (width_32),
    .hdr_valid  (hdr_valid),
    .hdr_error  (hdr_error)
);

// File: tb/tb_hdr_ratio_sel.sv
module tb_hdr_ratio_sel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_start = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_end = 1'b0;
    logic        wide_sel = 1'b0;
    logic        pad_start = 1'b0;
    logic        early_user = 1'b0;
    logic [1:0]  ratio_code;
    logic        width_32;
    logic        hdr_valid;
    logic        hdr_error;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hdr_ratio_sel dut (
        .clk        (clk),
        .rst        (rst),
        .s_start    (s_start),
        .s_data     (s_data),
        .s_valid    (s_valid),
        .s_end      (s_end),
        .wide_sel   (wide_sel),
        .pad_start  (pad_start),
        .early_user (early_user),
        .ratio_code (ratio_code),
        .width_32   (width_32),
        .hdr_valid  (hdr_valid),
        .hdr_error  (hdr_error)
    );

    // {enc field[1:0], word-229 bit 1, wide, expected code[1:0]}
    localparam logic [5:0] VEC [0:10] = '{
        6'b00_1_0_00,  // R4 plain, 16-bit
        6'b00_1_1_00,  // R4 plain, 32-bit
        6'b00_0_0_10,  // R5 compressed, 16-bit
        6'b00_0_1_11,  // R5 compressed, 32-bit
        6'b01_1_0_01,  // R6 encrypted, 16-bit
        6'b10_1_1_10,  // R6 encrypted, 32-bit
        6'b11_1_0_01,  // R2 field 11, 16-bit
        6'b01_0_0_10,  // R5 both, 16-bit
        6'b11_0_1_11,  // R5 both, 32-bit
        6'b10_0_1_11,  // R5 both, 32-bit
        6'b11_1_1_10   // R6 encrypted, 32-bit
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr69(input logic [1:0] enc);
        return 32'h5A5A_5A53 & ~32'h0000_000C | {28'd0, enc, 2'b00};
    endfunction

    function automatic logic [31:0] hdr229(input logic cmpbit);
        return 32'hFFFF_FFFD | {30'd0, cmpbit, 1'b0};
    endfunction

    // Opens a stream and sends n words; fill words and gap data would
    // look encrypted and compressed if captured anywhere else (R11).
    task automatic send_stream(input int n, input logic [31:0] w69, input logic [31:0] w229,
                               input logic wide, input logic end_last, input logic end_after,
                               output logic early_valid);
        early_valid = 1'b0;
        @(negedge clk);
        s_start = 1'b1;
        s_valid = 1'b1;
        s_data  = 32'h0000_000C;
        @(negedge clk);
        s_start  = 1'b0;
        wide_sel = wide;
        for (int i = 0; i < n; i++) begin
            if (i % 7 == 3) begin
                s_valid = 1'b0;
                s_data  = 32'h0000_000C;
                @(negedge clk);
            end
            s_valid = 1'b1;
            s_data  = (i == 69) ? w69 : (i == 229) ? w229 : 32'h0000_000C;
            s_end   = end_last && (i == n - 1);
            if (i == 229) early_valid = hdr_valid;
            @(negedge clk);
        end
        s_valid  = 1'b0;
        s_end    = 1'b0;
        s_data   = 32'h0000_000C;
        wide_sel = ~wide;
        if (end_after) begin
            s_end = 1'b1;
            @(negedge clk);
            s_end = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        logic ev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ratio_code", ratio_code, 0);
        chk("R1 width_32", width_32, 0);
        chk("R1 hdr_valid", hdr_valid, 0);
        chk("R1 hdr_error", hdr_error, 0);

        foreach (VEC[k]) begin
            send_stream(230, hdr69(VEC[k][5:4]), hdr229(VEC[k][3]), VEC[k][2], 1'b0, 1'b1, ev);
            chk($sformatf("R7 valid low at word 229 vec%0d", k), ev, 0);
            chk($sformatf("R2/R3/R4/R5/R6 code vec%0d", k), ratio_code, VEC[k][1:0]);
            chk($sformatf("R7 width vec%0d", k), width_32, VEC[k][2]);
            chk($sformatf("R7 valid vec%0d", k), hdr_valid, 1);
            chk($sformatf("R8 no error vec%0d", k), hdr_error, 0);
        end

        // R11: fill with indicator-like data, header says plain
        send_stream(240, hdr69(2'b00), hdr229(1'b1), 1'b1, 1'b0, 1'b1, ev);
        chk("R11 fill ignored code", ratio_code, 0);
        chk("R8 longer stream no error", hdr_error, 0);

        // R8: 229 words then end
        send_stream(229, hdr69(2'b01), hdr229(1'b0), 1'b1, 1'b0, 1'b1, ev);
        chk("R8 short 229 error", hdr_error, 1);
        chk("R8 short 229 valid", hdr_valid, 0);
        // R11: a word after the end at what would be index 229
        s_valid = 1'b1;
        s_data  = hdr229(1'b0);
        @(negedge clk);
        s_valid = 1'b0;
        @(negedge clk);
        chk("R11 word after end valid", hdr_valid, 0);
        chk("R11 word after end code", ratio_code, 0);
        chk("R9 error held", hdr_error, 1);

        send_stream(100, hdr69(2'b00), hdr229(1'b1), 1'b0, 1'b0, 1'b1, ev);
        chk("R8 short 100 error", hdr_error, 1);

        // R8 boundary: end on word 229 itself
        send_stream(230, hdr69(2'b10), hdr229(1'b1), 1'b0, 1'b1, 1'b0, ev);
        chk("R8 end with last word error", hdr_error, 0);
        chk("R8 end with last word valid", hdr_valid, 1);
        chk("R6 end with last word code", ratio_code, 1);

        // R10 over a stored x8 result
        send_stream(230, hdr69(2'b00), hdr229(1'b0), 1'b1, 1'b0, 1'b1, ev);
        chk("R5 x8 before pad", ratio_code, 3);
        pad_start = 1'b1;
        @(negedge clk);
        pad_start = 1'b0;
        chk("R10 pad forces x1", ratio_code, 0);
        repeat (5) @(negedge clk);
        chk("R10 pad holds x1", ratio_code, 0);
        chk("R10 width untouched", width_32, 1);
        early_user = 1'b1;
        @(negedge clk);
        early_user = 1'b0;
        chk("R10 restored code", ratio_code, 3);
        pad_start  = 1'b1;
        early_user = 1'b1;
        @(negedge clk);
        pad_start  = 1'b0;
        early_user = 1'b0;
        chk("R10 early_user wins", ratio_code, 3);

        // R9: start clears
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk("R9 start clears valid", hdr_valid, 0);
        chk("R9 start clears code", ratio_code, 0);
        chk("R9 start clears width", width_32, 0);
        chk("R9 start clears error", hdr_error, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule